// File: doc/BRIEF.md
# Hash Message Padding Unit

A streaming padder placed in front of an MD5 or SHA-1 compression core. Message bytes arrive as 32-bit words on a valid/ready input, with a last flag and a byte count for the final word. The unit forwards the data words unchanged. It then appends the one-bit terminator and the zero fill, and it places the 64-bit message bit count in the last two words of the closing 512-bit block. Every block leaves the unit as sixteen 32-bit words on a valid/ready output, and the sixteenth word carries a block-end marker.

Byte order follows the selected algorithm. SHA-1 packs the earliest byte of a word into bits [31:24] and writes the bit count big-endian. MD5 packs the earliest byte into bits [7:0] and writes the count little-endian. A prefix input adds one 512-bit block to the bit count. This covers a keyed-hash pass whose key block has already been absorbed by the core, either the inner pass or the outer pass over a 16- or 20-byte digest. The algorithm select and the prefix flag are sampled with the first word of each message.

Top module: `hash_pad`

## Requirements
- R1: While message words are being accepted, each input word appears on the output in the same cycle, and `in_ready_o` is high only when `out_ready_i` is high. Every message word is emitted exactly once, in order.
- R2: `in_bytes_i` gives the number of valid bytes in the last word: 0 means 4, and 1 to 3 mean that many. Bytes past the count are output as zero. In SHA-1 mode byte k of a word sits at bits [31-8k -: 8]; in MD5 mode it sits at bits [8k +: 8].
- R3: The byte 0x80 follows the last message byte directly. If the last word is partial, 0x80 takes the next byte position of that word. If the last word is full, the next output word is 0x80000000 in SHA-1 mode or 0x00000080 in MD5 mode. A message of a multiple of 64 bytes therefore starts an extra block with this word.
- R4: After the terminator, zero words fill the block up to word index 14. If the terminator lands in word 14 or 15, the block is completed with zeros and one more block follows, with zeros in words 0 to 13.
- R5: Words 14 and 15 of the closing block hold the 64-bit bit count T. In SHA-1 mode word 14 is T[63:32] and word 15 is T[31:0]. In MD5 mode word 14 is T[31:0] and word 15 is T[63:32].
- R6: T equals 8 times the message byte count. If `prefix_i` is high with the first word, T equals 8 times the byte count plus 512.
- R7: Output words come in groups of sixteen per 512-bit block. `out_last_o` is high on word 15 of every block and low on every other word.
- R8: A padding or length word presented with `out_ready_i` low stays valid and unchanged until it is accepted. No word is dropped or repeated under backpressure.
- R9: After reset the unit is waiting for a message, with `out_valid_o` low while `in_valid_i` is low, and the byte and word counters at zero. Once the last length word is accepted, the counters return to zero for the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| algo_sha_i | input | 1 | 1 = SHA-1 order, 0 = MD5 order; sampled with the first word |
| prefix_i | input | 1 | Add 512 to the bit count; sampled with the first word |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted |
| in_data_i | input | 32 | Message word |
| in_last_i | input | 1 | Last word of message |
| in_bytes_i | input | 2 | Valid bytes in last word (0 = 4) |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 32 | Block word |
| out_last_o | output | 1 | Word 15 of a block |

## Verification
The bench builds the unit with a 16-bit byte counter. This keeps the bit-count arithmetic small, and it still allows every message length from 1 to 130 bytes. That sweep is run for both algorithms, with and without the prefix. Across it, the terminator lands in every byte position and every word index, including words 14 and 15 and the exact-multiple-of-64 cases, and one-, two- and three-block results all occur. A pseudo-random pattern throttles both the input valid and the output ready, so every padding state sees stalls. The expected stream is built byte by byte from the standard padding rule and then packed into words in each algorithm's order.

// File: rtl/hash_pad_pkg.sv
package hash_pad_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BLK_WORDS = 16;
  localparam int unsigned IDX_W     = $clog2(BLK_WORDS);
  localparam int unsigned TOT_W     = 64;

  typedef enum logic [1:0] {
    ST_DATA,
    ST_TERM,
    ST_FILL,
    ST_LEN
  } hp_state_e;
endpackage

// File: rtl/hp_len.sv
module hp_len
  import hash_pad_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [2:0]       add_bytes_i,
  input  logic             first_i,
  input  logic             prefix_i,
  input  logic             clr_i,
  output logic [TOT_W-1:0] total_o
);
  localparam int unsigned PAD_W = TOT_W - CNT_W - 3;

  logic [CNT_W-1:0] cnt_q;
  logic             pfx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pfx_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      pfx_q <= 1'b0;
    end else if (add_i) begin
      cnt_q <= cnt_q + CNT_W'(add_bytes_i);
      if (first_i) pfx_q <= prefix_i;
    end
  end

  assign total_o = {{PAD_W{1'b0}}, cnt_q, 3'b000} + (pfx_q ? TOT_W'(512) : '0);

  // R9
  cnt_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !add_i) |=> (cnt_q == '0));
endmodule

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hash_pad_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             algo_sha_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  input  logic [1:0]       in_bytes_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  output hp_state_e        state_o,
  output logic [IDX_W-1:0] widx_o,
  output logic             sha_o,
  output logic             first_o,
  output logic             add_o,
  output logic [2:0]       add_bytes_o,
  output logic             clr_o
);
  hp_state_e        state_q, state_d;
  logic [IDX_W-1:0] widx_q;
  logic             first_q, sha_q;
  logic             in_fire, out_fire;

  assign in_ready_o  = (state_q == ST_DATA) && out_ready_i;
  assign out_valid_o = (state_q == ST_DATA) ? in_valid_i : 1'b1;
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;
  assign out_last_o  = (widx_q == IDX_W'(BLK_WORDS - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_DATA: if (in_fire && in_last_i) state_d = (in_bytes_i == 2'd0) ? ST_TERM : ST_FILL;
      ST_TERM: if (out_fire) state_d = ST_FILL;
      ST_FILL: if (out_fire && widx_q == IDX_W'(BLK_WORDS - 2)) state_d = ST_LEN;
      ST_LEN:  if (out_fire) state_d = ST_DATA;
      default: state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DATA;
      widx_q  <= '0;
      first_q <= 1'b1;
      sha_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (out_fire) widx_q <= widx_q + 1'b1;
      if (in_fire && first_q) begin
        sha_q   <= algo_sha_i;
        first_q <= 1'b0;
      end else if (out_fire && state_q == ST_LEN) begin
        first_q <= 1'b1;
      end
    end
  end

  assign state_o     = state_q;
  assign widx_o      = widx_q;
  assign sha_o       = (state_q == ST_DATA && first_q) ? algo_sha_i : sha_q;
  assign first_o     = first_q;
  assign add_o       = in_fire;
  assign add_bytes_o = (in_last_i && in_bytes_i != 2'd0) ? {1'b0, in_bytes_i} : 3'd4;
  assign clr_o       = out_fire && (state_q == ST_LEN);

  // R1
  in_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> out_ready_i);
  // R7
  len_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEN) |-> out_last_o);
endmodule

// File: rtl/hp_word_fmt.sv
module hp_word_fmt
  import hash_pad_pkg::*;
(
  input  hp_state_e        state_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             sha_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic             last_i,
  input  logic [1:0]       bytes_i,
  input  logic [TOT_W-1:0] total_i,
  output logic [WORD_W-1:0] word_o
);
  logic [4:0]        sh;
  logic [WORD_W-1:0] keep, term, tail, hi_w, lo_w;

  assign sh   = {bytes_i, 3'b000};
  assign keep = sha_i ? ~({WORD_W{1'b1}} >> sh) : ~({WORD_W{1'b1}} << sh);
  assign term = sha_i ? (32'h8000_0000 >> sh) : (32'h0000_0080 << sh);
  assign tail = (bytes_i == 2'd0) ? data_i : ((data_i & keep) | term);
  assign hi_w = total_i[TOT_W-1:WORD_W];
  assign lo_w = total_i[WORD_W-1:0];

  always_comb begin
    unique case (state_i)
      ST_DATA: word_o = last_i ? tail : data_i;
      ST_TERM: word_o = sha_i ? 32'h8000_0000 : 32'h0000_0080;
      ST_FILL: word_o = (widx_i == IDX_W'(BLK_WORDS - 2)) ? (sha_i ? hi_w : lo_w) : '0;
      ST_LEN:  word_o = sha_i ? lo_w : hi_w;
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/hash_pad.sv
module hash_pad
  import hash_pad_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        algo_sha_i,
  input  logic        prefix_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [31:0] in_data_i,
  input  logic        in_last_i,
  input  logic [1:0]  in_bytes_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [31:0] out_data_o,
  output logic        out_last_o
);
  hp_state_e        state;
  logic [IDX_W-1:0] widx;
  logic             sha, first, add, clr;
  logic [2:0]       add_bytes;
  logic [TOT_W-1:0] total;

  hp_ctrl u_ctrl (
    .clk_i, .rst_ni, .algo_sha_i, .in_valid_i, .in_last_i, .in_bytes_i,
    .out_ready_i, .in_ready_o, .out_valid_o, .out_last_o,
    .state_o(state), .widx_o(widx), .sha_o(sha), .first_o(first),
    .add_o(add), .add_bytes_o(add_bytes), .clr_o(clr)
  );

  hp_len #(.CNT_W(CNT_W)) u_len (
    .clk_i, .rst_ni, .add_i(add), .add_bytes_i(add_bytes), .first_i(first),
    .prefix_i, .clr_i(clr), .total_o(total)
  );

  hp_word_fmt u_fmt (
    .state_i(state), .widx_i(widx), .sha_i(sha), .data_i(in_data_i),
    .last_i(in_last_i), .bytes_i(in_bytes_i), .total_i(total), .word_o(out_data_o)
  );

  // R8
  pad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && state != ST_DATA) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: tb/hash_pad_tb_top.sv
module hash_pad_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        algo_sha = 1'b0, prefix = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [1:0]  in_bytes = 2'd0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_last;
  logic [31:0] out_data;

  int unsigned n_tests = 0, n_fail = 0;
  logic [15:0] lf = 16'hACE1;
  logic [7:0]  pb [0:255];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  hash_pad #(.CNT_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .algo_sha_i(algo_sha), .prefix_i(prefix),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_last_i(in_last), .in_bytes_i(in_bytes), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] msg_byte(int k, int len);
    return 8'((k * 37 + len * 5 + 13) & 255);
  endfunction

  function automatic logic [31:0] pack(logic [7:0] b0, logic [7:0] b1,
                                       logic [7:0] b2, logic [7:0] b3, bit sha);
    return sha ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  task automatic run_msg(int len, bit sha, bit pfx);
    int nexp, nw, oi, wi;
    logic [63:0] tot;
    logic [7:0]  ib [0:3];
    bit stall, drop_in;
    logic [31:0] stall_d, ew;
    string tag;
    nexp = ((len + 8) / 64 + 1) * 64;
    for (int k = 0; k < 256; k++) pb[k] = 8'h00;
    for (int k = 0; k < len; k++) pb[k] = msg_byte(k, len);
    pb[len] = 8'h80;
    tot = 64'(len) * 8 + (pfx ? 64'd512 : 64'd0);
    for (int j = 0; j < 8; j++)
      pb[nexp - 8 + j] = sha ? tot[63 - 8*j -: 8] : tot[8*j +: 8];
    nexp = nexp / 4;
    nw = (len + 3) / 4;
    oi = 0; wi = 0; stall = 0; drop_in = 0; stall_d = '0;
    algo_sha = sha; prefix = pfx;
    while (oi < nexp) begin
      @(negedge clk); #1;
      if (drop_in) begin in_valid = 1'b0; drop_in = 0; end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = lf[0] | lf[2];
      if (!in_valid && wi < nw && (lf[4] | lf[6])) begin
        for (int b = 0; b < 4; b++)
          ib[b] = (wi*4 + b < len) ? msg_byte(wi*4 + b, len) : 8'hA5;
        in_data  = pack(ib[0], ib[1], ib[2], ib[3], sha);
        in_last  = (wi == nw - 1);
        in_bytes = (wi == nw - 1) ? 2'(len % 4) : 2'd0;
        in_valid = 1'b1;
      end
      #1;
      if (stall) begin
        chk("R8 held valid", {31'd0, out_valid}, 32'd1);
        chk("R8 held data", out_data, stall_d);
      end
      stall   = out_valid && !out_ready;
      stall_d = out_data;
      if (out_valid && out_ready) begin
        ew = pack(pb[4*oi], pb[4*oi+1], pb[4*oi+2], pb[4*oi+3], sha);
        if (oi < nw - 1)          tag = "R1 data";
        else if (oi == nw - 1)    tag = "R2 R3 last word";
        else if (oi >= nexp - 2)  tag = pfx ? "R5 R6 length" : "R5 length";
        else                      tag = "R3 R4 pad";
        chk($sformatf("%s len=%0d sha=%0d pfx=%0d w=%0d", tag, len, sha, pfx, oi), out_data, ew);
        chk($sformatf("R7 marker len=%0d w=%0d", len, oi), {31'd0, out_last},
            {31'd0, (oi % 16) == 15});
        oi++;
      end
      if (in_valid && in_ready) begin wi++; drop_in = 1; end
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    chk($sformatf("R1 R9 all words taken len=%0d", len), 32'(wi), 32'(nw));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R9 reset valid low", {31'd0, out_valid}, 32'd0);
    chk("R9 reset marker low", {31'd0, out_last}, 32'd0);
    out_ready = 1'b0; rst_n = 1'b1; #1;
    chk("R1 ready gated low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1; #1;
    chk("R1 ready follows", {31'd0, in_ready}, 32'd1);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++)
        for (int l = 1; l <= 130; l++)
          run_msg(l, s[0], p[0]);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule